// File: doc/BRIEF.md
# Load/Store Access Fault Checker

This block sits beside the data-memory port of a 32-bit core and inspects every load and store the core issues. For each accepted access it decides whether the address is out of step with the access size, or whether it falls outside a programmable stack window. When either fault is found, it captures the faulting address and a packed status word and, where the rules allow, raises a trap request toward the core's exception logic.

Accesses arrive on a valid/ready channel. `acc_ready` is tied high: the checker never applies back-pressure, so every cycle with `acc_valid` high is an accepted access. The verdict is registered. The status registers and the trap pulse change on the clock edge that accepts the access, so the core sees the result one cycle after it presents the access. The stack bounds, the stack-check enable and the exception-enable bit are plain control inputs. They are sampled together with the access.

Top module: `dacc_checker`

## Requirements
- R1: An access is misaligned when `acc_addr & acc_mask` is non-zero. The size code is 0 for a byte, 1 for a halfword and 3 for a word. A byte access is never misaligned.
- R2: On a misaligned access, `fault_addr` is loaded with the access address.
- R3: The misalignment status word puts the cause code 1 in bits 4:0, the destination register index in bits 9:5, the write flag in bit 10, and a 1 in bit 11 when the size code is 3. All other bits are zero.
- R4: A misaligned access raises `trap_req` only when `exc_en` is high. When `exc_en` is low, `fault_addr` and `fault_status` are still updated.
- R5: When `stk_chk_en` is high, an access violates the stack window when its address is below `stk_lo` or above `stk_hi`. Addresses equal to either bound are valid. When `stk_chk_en` is low, no stack violation is detected.
- R6: On a stack violation, `fault_addr` gets the address and `fault_status` gets cause code 7 in bits 4:0, with all other bits zero. `trap_req` is raised whatever the value of `exc_en`.
- R7: When one access is both misaligned and outside the stack window, the misalignment outcome (R2 to R4) applies and the stack outcome does not.
- R8: `trap_req` is a single-cycle pulse. It is registered on the same edge that updates `fault_addr` and `fault_status`, and it is visible in the cycle after the access.
- R9: A cycle with no accepted access, or an accepted access with no fault, leaves `fault_addr` and `fault_status` unchanged and keeps `trap_req` low.
- R10: While `rst_n` is low, `fault_addr`, `fault_status` and `trap_req` are zero.
- R11: `acc_ready` is always high (no back-pressure).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_ready | output | 1 | Always high; the checker never stalls |
| acc_addr | input | 32 | Effective byte address of the access |
| acc_mask | input | 2 | Size code: 0 byte, 1 halfword, 3 word |
| acc_wr | input | 1 | 1 for a store, 0 for a load |
| acc_rd | input | 5 | Destination or source register index |
| stk_chk_en | input | 1 | Enables the stack window check for this access |
| stk_lo | input | 32 | Lowest valid stack address (inclusive) |
| stk_hi | input | 32 | Highest valid stack address (inclusive) |
| exc_en | input | 1 | Exception enable for misalignment traps |
| fault_addr | output | 32 | Captured faulting address |
| fault_status | output | 32 | Captured status word |
| trap_req | output | 1 | One-cycle trap request |

## Verification
The bench builds the checker with its default parameters: a 32-bit address, a 2-bit size code and a 5-bit register index. These widths put every status-word field at its final position, so the bench can check the write flag at bit 10, the register index up to 31 and the word flag at bit 11 against literal values. With a full 32-bit address, the stack window can be placed inside the address space with room on both sides. This puts the exact bounds and the addresses just outside them within reach, as well as an address that is both below the window and misaligned, which exercises the priority rule.

// File: rtl/dacc_chk_pkg.sv
package dacc_chk_pkg;

  // Cause codes carried in the low bits of the status word
  localparam int CAUSE_W = 5;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE     = 5'd0,
    CAUSE_MISALIGN = 5'd1,
    CAUSE_STACK    = 5'd7
  } cause_e;

  // Fixed field positions that the exception handler decodes
  localparam int RD_LSB   = 5;
  localparam int WR_BIT   = 10;
  localparam int WORD_BIT = 11;

  // Kind of fault chosen for one access
  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_ALIGN = 2'd1,
    FLT_STACK = 2'd2
  } fault_e;

endpackage

// File: rtl/dacc_align_det.sv
module dacc_align_det #(
  parameter int ADDR_W = 32,
  parameter int MASK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [MASK_W-1:0] mask,
  output logic              misaligned,
  output logic              is_word
);

  localparam logic [MASK_W-1:0] WORD_MASK = {MASK_W{1'b1}};

  logic [MASK_W-1:0] low_bits;

  // Only the low address bits can meet the mask
  assign low_bits   = addr[MASK_W-1:0] & mask;
  assign misaligned = |low_bits;
  assign is_word    = (mask == WORD_MASK);

  // Byte accesses can never be flagged
  assert_byte_never_misaligned_R1 : assert property (
    @(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !misaligned
  );

endmodule

// File: rtl/dacc_stack_win.sv
module dacc_stack_win #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  output logic              violation
);

  logic below;
  logic above;

  // Bounds are inclusive: lo and hi themselves are valid
  assign below     = addr < lo;
  assign above     = addr > hi;
  assign violation = chk_en & (below | above);

  assert_stack_needs_enable_R5 : assert property (
    @(posedge clk) disable iff (!rst_n)
    violation |-> chk_en
  );

  assert_bounds_inclusive_R5 : assert property (
    @(posedge clk) disable iff (!rst_n)
    ((addr == lo) && (lo <= hi)) |-> !violation
  );

endmodule

// File: rtl/dacc_exc_rec.sv
module dacc_exc_rec
  import dacc_chk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int RD_W   = 5,
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_fire,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [RD_W-1:0]   rd,
  input  logic              misaligned,
  input  logic              is_word,
  input  logic              stk_viol,
  input  logic              exc_en,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [STAT_W-1:0] fault_status,
  output logic              trap_req
);

  localparam int PAD_W = STAT_W - (WORD_BIT + 1);

  fault_e            kind;
  logic [STAT_W-1:0] align_word;
  logic [STAT_W-1:0] stack_word;
  logic [STAT_W-1:0] next_status;
  logic              take;
  logic              next_trap;

  // Misalignment outranks the stack window
  always_comb begin
    kind = FLT_NONE;
    if (acc_fire) begin
      if (misaligned)    kind = FLT_ALIGN;
      else if (stk_viol) kind = FLT_STACK;
    end
  end

  assign align_word = {{PAD_W{1'b0}}, is_word, wr, rd, CAUSE_MISALIGN};
  assign stack_word = {{(STAT_W-CAUSE_W){1'b0}}, CAUSE_STACK};

  always_comb begin
    take        = 1'b0;
    next_trap   = 1'b0;
    next_status = fault_status;
    unique case (kind)
      FLT_ALIGN: begin
        take        = 1'b1;
        next_status = align_word;
        next_trap   = exc_en;
      end
      FLT_STACK: begin
        take        = 1'b1;
        next_status = stack_word;
        next_trap   = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_addr   <= '0;
      fault_status <= '0;
      trap_req     <= 1'b0;
    end else begin
      trap_req <= next_trap;
      if (take) begin
        fault_addr   <= addr;
        fault_status <= next_status;
      end
    end
  end

  assert_align_captures_addr_R2 : assert property (
    @(posedge clk) disable iff (!rst_n)
    (acc_fire && misaligned) |=> (fault_addr == $past(addr))
  );

  assert_align_status_fields_R3 : assert property (
    @(posedge clk) disable iff (!rst_n)
    (acc_fire && misaligned) |=>
      (fault_status[CAUSE_W-1:0] == CAUSE_MISALIGN) &&
      (fault_status[WR_BIT] == $past(wr)) &&
      (fault_status[WORD_BIT] == $past(is_word))
  );

  assert_align_quiet_when_disabled_R4 : assert property (
    @(posedge clk) disable iff (!rst_n)
    (acc_fire && misaligned && !exc_en) |=> !trap_req
  );

  assert_stack_always_traps_R6 : assert property (
    @(posedge clk) disable iff (!rst_n)
    (acc_fire && stk_viol && !misaligned) |=>
      (trap_req && fault_status[CAUSE_W-1:0] == CAUSE_STACK)
  );

  assert_align_wins_R7 : assert property (
    @(posedge clk) disable iff (!rst_n)
    (acc_fire && misaligned && stk_viol) |=>
      (fault_status[CAUSE_W-1:0] == CAUSE_MISALIGN)
  );

  assert_trap_follows_access_R8 : assert property (
    @(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(acc_fire)
  );

  assert_idle_holds_state_R9 : assert property (
    @(posedge clk) disable iff (!rst_n)
    !acc_fire |=> ($stable(fault_addr) && $stable(fault_status) && !trap_req)
  );

endmodule

// File: rtl/dacc_checker.sv
module dacc_checker #(
  parameter int ADDR_W = 32,
  parameter int MASK_W = 2,
  parameter int RD_W   = 5,
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [MASK_W-1:0] acc_mask,
  input  logic              acc_wr,
  input  logic [RD_W-1:0]   acc_rd,
  input  logic              stk_chk_en,
  input  logic [ADDR_W-1:0] stk_lo,
  input  logic [ADDR_W-1:0] stk_hi,
  input  logic              exc_en,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [STAT_W-1:0] fault_status,
  output logic              trap_req
);

  logic acc_fire;
  logic mis;
  logic word_sz;
  logic stk_bad;

  // The checker is purely combinational up to the capture registers
  assign acc_ready = 1'b1;
  assign acc_fire  = acc_valid & acc_ready;

  dacc_align_det #(
    .ADDR_W (ADDR_W),
    .MASK_W (MASK_W)
  ) u_align (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (acc_addr),
    .mask       (acc_mask),
    .misaligned (mis),
    .is_word    (word_sz)
  );

  dacc_stack_win #(
    .ADDR_W (ADDR_W)
  ) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_en    (stk_chk_en),
    .addr      (acc_addr),
    .lo        (stk_lo),
    .hi        (stk_hi),
    .violation (stk_bad)
  );

  dacc_exc_rec #(
    .ADDR_W (ADDR_W),
    .RD_W   (RD_W),
    .STAT_W (STAT_W)
  ) u_rec (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_fire     (acc_fire),
    .addr         (acc_addr),
    .wr           (acc_wr),
    .rd           (acc_rd),
    .misaligned   (mis),
    .is_word      (word_sz),
    .stk_viol     (stk_bad),
    .exc_en       (exc_en),
    .fault_addr   (fault_addr),
    .fault_status (fault_status),
    .trap_req     (trap_req)
  );

  assert_never_stalls_R11 : assert property (
    @(posedge clk) disable iff (!rst_n)
    acc_ready
  );

endmodule

// File: tb/tb_dacc_checker.sv
module tb_dacc_checker;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid;
  logic        acc_ready;
  logic [31:0] acc_addr;
  logic [1:0]  acc_mask;
  logic        acc_wr;
  logic [4:0]  acc_rd;
  logic        stk_chk_en;
  logic [31:0] stk_lo;
  logic [31:0] stk_hi;
  logic        exc_en;
  logic [31:0] fault_addr;
  logic [31:0] fault_status;
  logic        trap_req;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] exp_ear = '0;
  logic [31:0] exp_esr = '0;

  always #10 clk = ~clk;

  dacc_checker dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid    (acc_valid),
    .acc_ready    (acc_ready),
    .acc_addr     (acc_addr),
    .acc_mask     (acc_mask),
    .acc_wr       (acc_wr),
    .acc_rd       (acc_rd),
    .stk_chk_en   (stk_chk_en),
    .stk_lo       (stk_lo),
    .stk_hi       (stk_hi),
    .exc_en       (exc_en),
    .fault_addr   (fault_addr),
    .fault_status (fault_status),
    .trap_req     (trap_req)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  mask;
    logic        wr;
    logic [4:0]  rd;
    logic        chk;
    logic        ee;
    logic        x_trap;
    logic        x_upd;
    logic [31:0] x_esr;
  } vec_t;

  // Window is 0x1000..0x1FFF inclusive for every row
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1002, 2'd1, 1'b0, 5'd3,  1'b1, 1'b1, 1'b0, 1'b0, 32'h0},     // R1 aligned half
    '{32'h0000_1003, 2'd1, 1'b1, 5'd5,  1'b1, 1'b1, 1'b1, 1'b1, 32'h4A1},   // R3 half store
    '{32'h0000_1002, 2'd3, 1'b0, 5'd31, 1'b1, 1'b1, 1'b1, 1'b1, 32'hBE1},   // R3 word load
    '{32'h0000_1001, 2'd3, 1'b1, 5'd0,  1'b1, 1'b0, 1'b0, 1'b1, 32'hC01},   // R4 no trap
    '{32'h0000_0FFC, 2'd3, 1'b0, 5'd1,  1'b1, 1'b0, 1'b1, 1'b1, 32'h7},     // R6 below, ee=0
    '{32'h0000_2000, 2'd0, 1'b1, 5'd9,  1'b1, 1'b1, 1'b1, 1'b1, 32'h7},     // R6 above
    '{32'h0000_1000, 2'd3, 1'b0, 5'd4,  1'b1, 1'b1, 1'b0, 1'b0, 32'h0},     // R5 low bound
    '{32'h0000_1FFF, 2'd0, 1'b0, 5'd4,  1'b1, 1'b1, 1'b0, 1'b0, 32'h0},     // R5 high bound
    '{32'h0000_0FFE, 2'd3, 1'b0, 5'd2,  1'b1, 1'b1, 1'b1, 1'b1, 32'h841},   // R7 both
    '{32'h0000_3000, 2'd0, 1'b0, 5'd6,  1'b0, 1'b1, 1'b0, 1'b0, 32'h0},     // R5 check off
    '{32'h0000_3001, 2'd0, 1'b1, 5'd6,  1'b0, 1'b1, 1'b0, 1'b0, 32'h0},     // R1 byte odd
    '{32'h0000_0002, 2'd1, 1'b0, 5'd7,  1'b0, 1'b1, 1'b0, 1'b0, 32'h0},     // R1 aligned
    '{32'hFFFF_FFFE, 2'd3, 1'b1, 5'd17, 1'b0, 1'b1, 1'b1, 1'b1, 32'hE21}    // R2 top address
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    acc_valid  = 1'b1;
    acc_addr   = v.addr;
    acc_mask   = v.mask;
    acc_wr     = v.wr;
    acc_rd     = v.rd;
    stk_chk_en = v.chk;
    exc_en     = v.ee;
  endtask

  task automatic check_row(input vec_t v, input string req);
    if (v.x_upd) begin
      exp_ear = v.addr;
      exp_esr = v.x_esr;
    end
    check(trap_req == v.x_trap, req, "trap", {31'b0, trap_req}, {31'b0, v.x_trap});
    check(fault_addr == exp_ear, req, "fault_addr", fault_addr, exp_ear);
    check(fault_status == exp_esr, req, "fault_status", fault_status, exp_esr);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; acc_valid = 1'b0; acc_addr = '0; acc_mask = '0;
    acc_wr = 1'b0; acc_rd = '0; stk_chk_en = 1'b0; exc_en = 1'b0;
    stk_lo = 32'h0000_1000; stk_hi = 32'h0000_1FFF;
    repeat (3) @(negedge clk);

    // R10 reset state
    check(fault_addr == 0 && fault_status == 0 && trap_req == 0, "R10", "reset",
          fault_status, 32'h0);
    check(acc_ready == 1'b1, "R11", "ready", {31'b0, acc_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: drive at a falling edge, check at the next one
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      check_row(VECS[i], "R1-table R2 R3 R4 R5 R6 R7");
      acc_valid = 1'b0;
      @(negedge clk);
      // R8 pulse lasts one cycle
      check(trap_req == 1'b0, "R8", "pulse width", {31'b0, trap_req}, 32'h0);
    end

    // R9 bad address without valid changes nothing
    acc_valid = 1'b0; acc_addr = 32'h0000_0003; acc_mask = 2'd3;
    stk_chk_en = 1'b1; exc_en = 1'b1;
    @(negedge clk);
    check(trap_req == 1'b0, "R9", "idle trap", {31'b0, trap_req}, 32'h0);
    check(fault_addr == exp_ear, "R9", "idle addr", fault_addr, exp_ear);
    check(fault_status == exp_esr, "R9", "idle status", fault_status, exp_esr);

    // R8 back-to-back faults give a pulse each cycle with fresh capture
    drive('{32'h0000_0801, 2'd1, 1'b0, 5'd8, 1'b1, 1'b1, 1'b1, 1'b1, 32'h101});
    @(negedge clk);
    check(trap_req && fault_status == 32'h101, "R8", "first of pair", fault_status, 32'h101);
    drive('{32'h0000_4000, 2'd0, 1'b0, 5'd8, 1'b1, 1'b0, 1'b1, 1'b1, 32'h7});
    @(negedge clk);
    check(trap_req && fault_status == 32'h7 && fault_addr == 32'h4000, "R8",
          "second of pair", fault_addr, 32'h4000);
    acc_valid = 1'b0;
    @(negedge clk);
    check(trap_req == 1'b0, "R8", "pair end", {31'b0, trap_req}, 32'h0);

    // R10 reset mid-run clears captured state
    rst_n = 1'b0;
    @(negedge clk);
    check(fault_addr == 0 && fault_status == 0, "R10", "reset clears", fault_addr, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule